// File: doc/BRIEF.md
# Chained-Datagram SPI Master

This block is an SPI master controlled through a small register bus. Software sets a bit-clock divider, a datagram length of 1 to 64 bits, a bit order, a target chip-select line and a hold flag. It then writes a 64-bit transmit word. Each datagram is shifted out in SPI mode 3. The bits returned on MISO are collected into a receive register.

The hold flag leaves the selected chip select asserted once a datagram ends. A long daisy chain of serial-in shift registers can therefore be loaded by several datagrams that form one frame. The next datagram of a held frame begins at once, with no chip-select setup interval. Only one datagram is in flight at a time. Software polls a ready bit before it touches the configuration or writes new data.

Top module: `spi_chain_master`

## Requirements
- R1: The SCLK period is 4+2T system clocks, where T is the timing register (address 0). SCLK stays low for 2+T clocks and high for 2+T clocks.
- R2: The length register (address 1) holds L-1. A datagram has exactly L rising SCLK edges. Transmit bits at positions L and above are never sent.
- R3: Configuration bit 0 selects the bit order. With 0, transmit bit L-1 goes out first and the order descends. With 1, bit 0 goes out first and the order ascends.
- R4: SCLK idles high. MOSI changes only together with a falling SCLK edge. MISO is sampled at each rising edge. Received bit k is stored at the position that transmit bit k was taken from. The receive register (address 4) reads 0 at every other position.
- R5: When configuration bit 5 is set, a write to the TX register (address 3) starts a datagram. When it is clear, that write only loads the data, and a write to the status address (5) starts the datagram.
- R6: Status bit 0 (ready) reads 1 after reset. It reads 0 in the cycle after a start and returns to 1 once the last bit's high phase has ended.
- R7: The hold flag is configuration bit 3. If it is set, the selected chip select stays low after the datagram and status bit 1 reads 1. If it is clear, chip select goes high in the same cycle that ready returns. A start while chip select is held drives SCLK low at the start edge.
- R8: If chip select is not held, it goes low at the start edge, and the first falling SCLK edge follows 2+T clocks later.
- R9: Configuration bits [9:8] choose which active-low chip select is driven. At most one chip-select line is ever low.
- R10: While ready is 0, writes to timing, length, configuration and TX, and start requests, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 timing, 1 length, 2 config, 3 TX, 4 RX, 5 status/start) |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that the bus drives only defined addresses. They also assume that MISO is stable whenever the master samples it. The driver meets both: it writes only in the middle of a clock period, and the slave model updates MISO only after each rising SCLK edge has been taken. The checks on frozen configuration rely on software that writes during a busy datagram. The stimulus does exactly that on purpose, so the property is exercised and not merely held by silence on the bus.

// File: rtl/spi_chain_master.sv
module spi_chain_master #(
  parameter int DW  = 64,
  parameter int TW  = 8,
  parameter int NCS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [NCS-1:0] spi_cs_n
);
  localparam int LW   = $clog2(DW);
  localparam int SW   = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int CW   = TW + 2;
  localparam int CFGW = 8 + SW;
  localparam logic [2:0] A_TIME = 3'd0, A_LEN = 3'd1, A_CFG = 3'd2,
                         A_TX = 3'd3, A_RX = 3'd4, A_STAT = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH} state_t;

  state_t          st;
  logic [TW-1:0]   tim_q;
  logic [LW-1:0]   len_q;
  logic [CFGW-1:0] cfg_q;
  logic [DW-1:0]   tx_q, rx_q;
  logic [CW-1:0]   cnt;
  logic [LW-1:0]   bitn;
  logic            sclk_q, mosi_q, cs_q;
  logic [SW-1:0]   ss_q;

  wire idle   = (st == ST_IDLE);
  wire wr_tx  = bus_wr && (bus_addr == A_TX);
  wire start  = idle && bus_wr && ((bus_addr == A_TX && cfg_q[5]) || bus_addr == A_STAT);
  wire [CW-1:0] half_m1 = CW'(tim_q) + CW'(1);
  wire [DW-1:0] tx_src  = wr_tx ? bus_wdata : tx_q;
  wire [LW-1:0] bit_nx  = bitn + LW'(1);

  function automatic logic [LW-1:0] pos(input logic [LW-1:0] b);
    pos = cfg_q[0] ? b : (len_q - b);
  endfunction

  assign spi_sclk = sclk_q;
  assign spi_mosi = mosi_q;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign spi_cs_n[i] = !(cs_q && (ss_q == SW'(i)));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TIME:  bus_rdata[TW-1:0]   = tim_q;
      A_LEN:   bus_rdata[LW-1:0]   = len_q;
      A_CFG:   bus_rdata[CFGW-1:0] = cfg_q;
      A_TX:    bus_rdata           = tx_q;
      A_RX:    bus_rdata           = rx_q;
      A_STAT:  bus_rdata[1:0]      = {cs_q, idle};
      default: bus_rdata           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tim_q  <= '0;
      len_q  <= '0;
      cfg_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt    <= '0;
      bitn   <= '0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      cs_q   <= 1'b0;
      ss_q   <= '0;
    end else begin
      if (idle && bus_wr) begin
        case (bus_addr)
          A_TIME:  tim_q <= bus_wdata[TW-1:0];
          A_LEN:   len_q <= bus_wdata[LW-1:0];
          A_CFG:   cfg_q <= bus_wdata[CFGW-1:0];
          A_TX:    tx_q  <= bus_wdata;
          default: ;
        endcase
      end
      case (st)
        ST_IDLE: if (start) begin
          rx_q <= '0;
          bitn <= '0;
          cnt  <= half_m1;
          if (cs_q) begin
            st     <= ST_LOW;
            sclk_q <= 1'b0;
            mosi_q <= tx_src[pos('0)];
          end else begin
            st   <= ST_SETUP;
            cs_q <= 1'b1;
            ss_q <= cfg_q[8 +: SW];
          end
        end
        ST_SETUP: if (cnt == '0) begin
          st     <= ST_LOW;
          sclk_q <= 1'b0;
          mosi_q <= tx_q[pos(bitn)];
          cnt    <= half_m1;
        end else cnt <= cnt - CW'(1);
        ST_LOW: if (cnt == '0) begin
          st              <= ST_HIGH;
          sclk_q          <= 1'b1;
          rx_q[pos(bitn)] <= spi_miso;
          cnt             <= half_m1;
        end else cnt <= cnt - CW'(1);
        ST_HIGH: if (cnt == '0) begin
          if (bitn == len_q) begin
            st   <= ST_IDLE;
            cs_q <= cfg_q[3];
          end else begin
            bitn   <= bit_nx;
            st     <= ST_LOW;
            sclk_q <= 1'b0;
            mosi_q <= tx_q[pos(bit_nx)];
            cnt    <= half_m1;
          end
        end else cnt <= cnt - CW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_one_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(spi_sclk) |-> $stable(spi_mosi));
  assert_sclk_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> spi_sclk);
  assert_busy_has_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (spi_cs_n != '1));
  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle);
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> ($stable(cfg_q) && $stable(len_q) && $stable(tim_q) && $stable(tx_q)));
endmodule

// File: tb/spi_chain_master_tb.sv
`timescale 1ns/1ps
module spi_chain_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  wire  [63:0] bus_rdata;
  wire         sclk, mosi;
  wire  [3:0]  cs_n;

  int total = 0, bad = 0;
  bit exp_q[$];
  logic [63:0] swd = '0;
  int sl_len = 1, sbit = 0, cur_len = 1;
  bit cur_lsb = 0;

  always #4 clk = ~clk;

  wire miso = (sbit < sl_len) ? swd[sl_len-1-sbit] : 1'b0;

  spi_chain_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n));

  always @(posedge sclk) sbit = sbit + 1;

  // monitor: each rising SCLK edge pops one expected MOSI bit (R2, R3)
  always begin
    @(posedge sclk);
    #1;
    if (rst_n) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2: extra SCLK edge act=bit exp=none");
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (mosi !== e) begin
          bad++;
          $display("FAIL R3: mosi act=%b exp=%b", mosi, e);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_ready();
    logic [63:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      rd(3'd5, s);
      n++;
    end while (!s[0] && n < 20000);
  endtask

  function automatic logic [63:0] cfgv(bit lsb, bit hold, bit auto_go, int ss);
    cfgv = 64'(lsb) | (64'(hold) << 3) | (64'(auto_go) << 5) | (64'(ss) << 8);
  endfunction

  task automatic expect_bits(input logic [63:0] d, input int len, input bit lsb, input logic [63:0] sw);
    for (int b = 0; b < len; b++) exp_q.push_back(d[lsb ? b : len-1-b]);
    swd = sw; sl_len = len; sbit = 0; cur_len = len; cur_lsb = lsb;
  endtask

  task automatic xfer_start(input logic [63:0] d, input int len, input bit lsb, input logic [63:0] sw);
    logic [63:0] s;
    expect_bits(d, len, lsb, sw);
    wr(3'd3, d);
    rd(3'd5, s);
    chk("R6", s[0], 1'b0, "ready in cycle after start");
  endtask

  task automatic xfer_finish();
    logic [63:0] r, e;
    wait_ready();
    chk("R2", exp_q.size(), 0, "bits left unsent");
    e = '0;
    for (int b = 0; b < cur_len; b++) e[cur_lsb ? b : cur_len-1-b] = swd[cur_len-1-b];
    rd(3'd4, r);
    chk("R4", r, e, "rx data");
  endtask

  task automatic phase_len(input bit lvl, output int n);
    n = 0;
    while (sclk === lvl) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] s;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, s);
    chk("R6", s[1:0], 2'b01, "status after reset");
    chk("R7", cs_n, 4'hF, "cs after reset");
    chk("R4", sclk, 1'b1, "sclk idle after reset");

    // R1 R8 R9 R2: T=3, 8 bits, slave 2
    wr(3'd0, 64'd3);
    wr(3'd1, 64'd7);
    wr(3'd2, cfgv(0, 0, 1, 2));
    xfer_start(64'hFFFF_FF00_0000_00A5, 8, 0, 64'h3C);
    chk("R9", cs_n, 4'b1011, "selected line");
    phase_len(1'b1, n); chk("R8", n, 5, "cs setup clocks");
    phase_len(1'b0, n); chk("R1", n, 5, "sclk low clocks");
    phase_len(1'b1, n); chk("R1", n, 5, "sclk high clocks");
    xfer_finish();
    chk("R7", cs_n, 4'hF, "cs released");

    // R7: held 64-bit datagram followed by a 16-bit tail, T=0
    wr(3'd0, 64'd0);
    wr(3'd1, 64'd63);
    wr(3'd2, cfgv(0, 1, 1, 0));
    xfer_start(64'h5555_AAAA_5555_AAAA, 64, 0, 64'h0123_4567_89AB_CDEF);
    phase_len(1'b1, n); chk("R8", n, 2, "cs setup T=0");
    xfer_finish();
    rd(3'd5, s);
    chk("R7", s[1], 1'b1, "hold status");
    chk("R7", cs_n, 4'b1110, "cs held low");
    wr(3'd1, 64'd15);
    wr(3'd2, cfgv(0, 0, 1, 0));
    xfer_start(64'h0000_0000_0000_55AA, 16, 0, 64'hBEEF);
    chk("R7", sclk, 1'b0, "no setup when held");
    xfer_finish();
    chk("R7", cs_n, 4'hF, "cs released at tail end");
    rd(3'd5, s);
    chk("R7", s[1], 1'b0, "hold status cleared");

    // R3: LSB first, slave 1, upper bits ignored
    wr(3'd2, cfgv(1, 0, 1, 1));
    xfer_start(64'hDEAD_0000_0000_1234, 16, 1, 64'hC001);
    chk("R9", cs_n, 4'b1101, "slave 1 line");
    xfer_finish();

    // R5: start command when auto start is off
    wr(3'd1, 64'd11);
    wr(3'd2, cfgv(0, 0, 0, 3));
    wr(3'd3, 64'h0000_0000_0000_0ABC);
    repeat (10) @(negedge clk);
    rd(3'd5, s);
    chk("R5", s[0], 1'b1, "tx write without auto start");
    chk("R5", sclk, 1'b1, "no clock without auto start");
    expect_bits(64'h0ABC, 12, 0, 64'h5A5);
    wr(3'd5, 64'd0);
    rd(3'd5, s);
    chk("R5", s[0], 1'b0, "start command");
    chk("R9", cs_n, 4'b0111, "slave 3 line");
    xfer_finish();

    // R10: writes while busy are ignored
    wr(3'd0, 64'd5);
    wr(3'd1, 64'd63);
    wr(3'd2, cfgv(0, 0, 1, 0));
    xfer_start(64'h0F0F_1234_8765_F0F0, 64, 0, 64'hFFFF_0000_1111_2222);
    wr(3'd1, 64'd3);
    wr(3'd2, cfgv(1, 1, 1, 2));
    wr(3'd0, 64'd0);
    wr(3'd3, 64'h1111_1111_1111_1111);
    wr(3'd5, 64'd0);
    xfer_finish();
    rd(3'd1, s); chk("R10", s, 64'd63, "length kept");
    rd(3'd0, s); chk("R10", s, 64'd5, "timing kept");
    rd(3'd2, s); chk("R10", s, cfgv(0, 0, 1, 0), "config kept");
    rd(3'd3, s); chk("R10", s, 64'h0F0F_1234_8765_F0F0, "tx kept");
    repeat (40) @(negedge clk);
    rd(3'd5, s);
    chk("R10", s[0], 1'b1, "busy start dropped");
    chk("R10", cs_n, 4'hF, "no cs after dropped start");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule